// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Bank

This block is the software-facing register file of a 32-pin general-purpose I/O controller. It sits on a simple 32-bit word bus. A request is one cycle of `bus_sel`, with `bus_wr` giving the direction. Writes take effect on the edge that accepts them. Read data returns on the following cycle, flagged by `bus_rvalid`.

The bank holds the pin data, the pin direction, the synchronized pad levels, a 64-bit interrupt configuration reached as two words, an interrupt mask, the interrupt status and an optional both-edge select word. It drives the output pins from the data word wherever the direction bit selects output. It samples the input pins through a synchronizer into the pad status.

The edge-detection block is separate. It receives the configuration, mask, status and both-edge words from here, together with the synchronized pad levels, and it reports new events back on `irq_set`.

A two-state bus sequencer controls the access flow:
- `ST_IDLE` means no read data is pending.
- `ST_RESP` means read data is being presented.

The sequencer moves between the states as follows:
- `ST_IDLE` to `ST_RESP`, or `ST_RESP` to `ST_RESP`: a read request is accepted.
- `ST_RESP` to `ST_IDLE`: no read is accepted on that edge.
- `ST_IDLE` to `ST_IDLE`: an idle cycle or a write.

Writes are accepted in both states.

Top module: `gpio_bank`

## Requirements
- R1: A direction bit of 1 makes that pin an output: `pin_oe` carries the direction bit and `pin_out` carries the data bit. A direction bit of 0 makes the pin an input, with `pin_oe` and `pin_out` both 0.
- R2: A read of the data word (offset 0x00) returns, bit by bit, the stored data bit for output pins and the synchronized pad bit for input pins.
- R3: A read of the pad status word (offset 0x08) returns the synchronized pad levels with every output-pin bit forced to 0.
- R4: The interrupt configuration is reached as two words. Bits 31:0 are at offset 0x0C and bits 63:32 are at offset 0x10. A write to one word leaves the other unchanged.
- R5: With `HAS_BOTH_EDGE`=1 the both-edge word at offset 0x1C is readable and writable. With `HAS_BOTH_EDGE`=0 it reads 0, writes to it have no effect and `ctl_both` stays 0.
- R6: Decoded word offsets are:
  - 0x00 data
  - 0x04 direction
  - 0x08 pad status
  - 0x0C configuration low
  - 0x10 configuration high
  - 0x14 mask
  - 0x18 status
  - 0x1C both-edge

  An address that is not 4-byte aligned, or that lies at or above 0x20, reads 0 and is ignored on write.
- R7: A read accepted on an edge raises `bus_rvalid`, with the data on `bus_rdata`, for the cycle after that edge. `bus_rvalid` is low in any cycle that does not follow an accepted read.
- R8: The interrupt status is handled as follows:
  - A bit is set by a 1 on `irq_set`.
  - Writing 1 to a status bit (offset 0x18) clears it, and writing 0 leaves it unchanged.
  - If a set and a clear hit the same bit in one cycle, the set wins.
- R9: Input pins pass through two flip-flops. A change on `pin_in` appears on `pad_level` after exactly two clock edges.
- R10: Reset clears every register: data, direction, pad status, configuration, mask, status and both-edge. All pins therefore start as inputs.
- R11: The mask word (offset 0x14) reads back what was written and is presented on `ctl_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Request valid for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid |
| pin_in | input | PINS | Raw input pin levels |
| pin_out | output | PINS | Output pin levels |
| pin_oe | output | PINS | Output enable per pin |
| irq_set | input | PINS | Status set requests from edge logic |
| pad_level | output | PINS | Synchronized pad levels |
| ctl_dir | output | PINS | Direction word |
| ctl_icfg | output | 2*PINS | Interrupt configuration |
| ctl_mask | output | PINS | Interrupt mask |
| ctl_stat | output | PINS | Interrupt status |
| ctl_both | output | PINS | Both-edge select |

## Verification
The assertions watch several properties on every cycle:
- output pins are only driven where the direction allows;
- read responses follow exactly the accepted reads;
- status bits requested by `irq_set` are present one edge later;
- the pad levels lag the pins by exactly two edges;
- writes to one configuration word or to an undecoded address leave the other state untouched.

Only the bench scenarios can show the remaining behaviour. This covers the direction-aware mixing of data and pad bits in readback and the masking of the pad status word. It also covers the absent both-edge variant, the write-one-to-clear status with its same-cycle priority, and the full clearing by a mid-run reset.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    typedef enum logic [2:0] {
        IDX_DATA  = 3'd0,
        IDX_DIR   = 3'd1,
        IDX_PAD   = 3'd2,
        IDX_CFG_L = 3'd3,
        IDX_CFG_H = 3'd4,
        IDX_MASK  = 3'd5,
        IDX_STAT  = 3'd6,
        IDX_BOTH  = 3'd7
    } reg_idx_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int PINS          = 32,
    parameter bit HAS_BOTH_EDGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_idx_t          wr_idx,
    input  logic [PINS-1:0]   wdata,
    input  logic [PINS-1:0]   irq_set,
    output logic [PINS-1:0]   data_q,
    output logic [PINS-1:0]   dir_q,
    output logic [2*PINS-1:0] cfg_q,
    output logic [PINS-1:0]   mask_q,
    output logic [PINS-1:0]   stat_q,
    output logic [PINS-1:0]   both_q
);
    logic [PINS-1:0] stat_clr;

    assign stat_clr = (wr_en && wr_idx == IDX_STAT) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            cfg_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            unique case (wr_idx)
                IDX_DATA:  data_q             <= wdata;
                IDX_DIR:   dir_q              <= wdata;
                IDX_CFG_L: cfg_q[PINS-1:0]    <= wdata;
                IDX_CFG_H: cfg_q[2*PINS-1:PINS] <= wdata;
                IDX_MASK:  mask_q             <= wdata;
                default:   ;
            endcase
        end
    end

    // set requests win over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | irq_set;
        end
    end

    generate
        if (HAS_BOTH_EDGE) begin : g_both
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    both_q <= '0;
                end else if (wr_en && wr_idx == IDX_BOTH) begin
                    both_q <= wdata;
                end
            end
        end else begin : g_no_both
            assign both_q = '0;
        end
    endgenerate
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PINS   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PINS-1:0]   data_q,
    input  logic [PINS-1:0]   dir_q,
    input  logic [PINS-1:0]   pad_q,
    input  logic [2*PINS-1:0] cfg_q,
    input  logic [PINS-1:0]   mask_q,
    input  logic [PINS-1:0]   stat_q,
    input  logic [PINS-1:0]   both_q,
    output logic              wr_en,
    output reg_idx_t          idx,
    output logic [PINS-1:0]   rdata,
    output logic              rvalid
);
    bus_state_t      state_q, state_d;
    logic            word_ok;
    logic            rd_acc;
    logic [PINS-1:0] rd_word;

    assign word_ok = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:5] == '0);
    assign idx     = reg_idx_t'(addr[4:2]);
    assign wr_en   = sel && wr && word_ok;
    assign rd_acc  = sel && !wr;

    always_comb begin
        unique case (idx)
            IDX_DATA:  rd_word = (data_q & dir_q) | (pad_q & ~dir_q);
            IDX_DIR:   rd_word = dir_q;
            IDX_PAD:   rd_word = pad_q & ~dir_q;
            IDX_CFG_L: rd_word = cfg_q[PINS-1:0];
            IDX_CFG_H: rd_word = cfg_q[2*PINS-1:PINS];
            IDX_MASK:  rd_word = mask_q;
            IDX_STAT:  rd_word = stat_q;
            IDX_BOTH:  rd_word = both_q;
            default:   rd_word = '0;
        endcase
        if (!word_ok) rd_word = '0;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_acc ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_acc ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_acc) rdata <= rd_word;
    end

    assign rvalid = (state_q == ST_RESP);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W        = 6,
    parameter int PINS          = 32,
    parameter int SYNC_STAGES   = 2,
    parameter bit HAS_BOTH_EDGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    output logic              bus_rvalid,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    input  logic [PINS-1:0]   irq_set,
    output logic [PINS-1:0]   pad_level,
    output logic [PINS-1:0]   ctl_dir,
    output logic [2*PINS-1:0] ctl_icfg,
    output logic [PINS-1:0]   ctl_mask,
    output logic [PINS-1:0]   ctl_stat,
    output logic [PINS-1:0]   ctl_both
);
    logic            wr_en;
    reg_idx_t        idx;
    logic [PINS-1:0] data_q;

    gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pad_level)
    );

    gpio_regs #(.PINS(PINS), .HAS_BOTH_EDGE(HAS_BOTH_EDGE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx),
        .wdata(bus_wdata), .irq_set(irq_set),
        .data_q(data_q), .dir_q(ctl_dir), .cfg_q(ctl_icfg),
        .mask_q(ctl_mask), .stat_q(ctl_stat), .both_q(ctl_both)
    );

    gpio_bus_fsm #(.ADDR_W(ADDR_W), .PINS(PINS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .data_q(data_q), .dir_q(ctl_dir), .pad_q(pad_level), .cfg_q(ctl_icfg),
        .mask_q(ctl_mask), .stat_q(ctl_stat), .both_q(ctl_both),
        .wr_en(wr_en), .idx(idx), .rdata(bus_rdata), .rvalid(bus_rvalid)
    );

    assign pin_oe  = ctl_dir;
    assign pin_out = data_q & ctl_dir;
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
    parameter int ADDR_W = 6,
    parameter int PINS   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rvalid,
    input logic [PINS-1:0]   pin_in,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe,
    input logic [PINS-1:0]   irq_set,
    input logic [PINS-1:0]   pad_level,
    input logic [PINS-1:0]   ctl_dir,
    input logic [2*PINS-1:0] ctl_icfg,
    input logic [PINS-1:0]   ctl_mask,
    input logic [PINS-1:0]   ctl_stat
);
    logic [1:0] since_rst;
    logic       bad_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    assign bad_addr = (bus_addr[1:0] != 2'b00) || (bus_addr[ADDR_W-1:5] != '0);

    // R1: pins drive only where the direction word selects output
    a_r1_out_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0) && (pin_oe == ctl_dir));

    a_r7_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);

    a_r7_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !bus_rvalid);

    a_r8_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set != '0) |=> ((ctl_stat & $past(irq_set)) == $past(irq_set)));

    a_r9_two_edge_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (pad_level == $past(pin_in, 2)));

    a_r4_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'('h0C)) |=> $stable(ctl_icfg[2*PINS-1:PINS]));

    a_r4_high_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'('h10)) |=> $stable(ctl_icfg[PINS-1:0]));

    a_r6_bad_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bad_addr) |=>
            ($stable(ctl_dir) && $stable(ctl_mask) && $stable(ctl_icfg)));
endmodule

bind gpio_bank gpio_bank_checker #(.ADDR_W(ADDR_W), .PINS(PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_set(irq_set),
    .pad_level(pad_level), .ctl_dir(ctl_dir), .ctl_icfg(ctl_icfg),
    .ctl_mask(ctl_mask), .ctl_stat(ctl_stat)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
    localparam int AW = 6;
    localparam int NP = 32;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [31:0]   data;
        logic [31:0]   exp;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'h04, 32'h0000FFFF, 32'h0},          // R1 direction: low half output
        '{1'b1, 6'h00, 32'h12345678, 32'h0},
        '{1'b0, 6'h04, 32'h0,        32'h0000FFFF},   // R1
        '{1'b0, 6'h00, 32'h0,        32'hA5A55678},   // R2 mix
        '{1'b0, 6'h08, 32'h0,        32'hA5A50000},   // R3 masked pads
        '{1'b1, 6'h0C, 32'hDEADBEEF, 32'h0},
        '{1'b1, 6'h10, 32'h01234567, 32'h0},
        '{1'b0, 6'h0C, 32'h0,        32'hDEADBEEF},   // R4
        '{1'b0, 6'h10, 32'h0,        32'h01234567},   // R4
        '{1'b1, 6'h0C, 32'h11111111, 32'h0},
        '{1'b0, 6'h10, 32'h0,        32'h01234567},   // R4 high kept
        '{1'b0, 6'h0C, 32'h0,        32'h11111111},   // R4
        '{1'b1, 6'h14, 32'hF0F0F0F0, 32'h0},
        '{1'b0, 6'h14, 32'h0,        32'hF0F0F0F0},   // R11
        '{1'b1, 6'h1C, 32'h0000000F, 32'h0},
        '{1'b0, 6'h1C, 32'h0,        32'h0000000F},   // R5 present
        '{1'b1, 6'h05, 32'hFFFFFFFF, 32'h0},          // R6 misaligned write
        '{1'b1, 6'h24, 32'hFFFFFFFF, 32'h0},          // R6 out-of-range write
        '{1'b0, 6'h04, 32'h0,        32'h0000FFFF},   // R6 direction untouched
        '{1'b0, 6'h20, 32'h0,        32'h0}           // R6 out-of-range read
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0, wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [NP-1:0] pin_in = '0, irq_set = '0;
    logic [31:0]   rdata, rdata_nb;
    logic          rvalid, rvalid_nb;
    logic [NP-1:0] pin_out, pin_oe, pad_level, ctl_dir, ctl_mask, ctl_stat, ctl_both;
    logic [NP-1:0] pin_out_nb, pin_oe_nb, pad_nb, dir_nb, mask_nb, stat_nb, both_nb;
    logic [2*NP-1:0] ctl_icfg, icfg_nb;
    int checks = 0, errors = 0;
    logic [31:0] got;

    always #5 clk = ~clk;

    gpio_bank #(.ADDR_W(AW), .PINS(NP), .HAS_BOTH_EDGE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_set(irq_set),
        .pad_level(pad_level), .ctl_dir(ctl_dir), .ctl_icfg(ctl_icfg),
        .ctl_mask(ctl_mask), .ctl_stat(ctl_stat), .ctl_both(ctl_both)
    );

    gpio_bank #(.ADDR_W(AW), .PINS(NP), .HAS_BOTH_EDGE(1'b0)) dut_nb_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_nb), .bus_rvalid(rvalid_nb),
        .pin_in(pin_in), .pin_out(pin_out_nb), .pin_oe(pin_oe_nb), .irq_set(irq_set),
        .pad_level(pad_nb), .ctl_dir(dir_nb), .ctl_icfg(icfg_nb),
        .ctl_mask(mask_nb), .ctl_stat(stat_nb), .ctl_both(both_nb)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        if (!rvalid) begin
            checks++; errors++;
            $display("FAIL R7 actual=rvalid 0 expected=rvalid 1");
        end
        d = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 oe", {32'h0, pin_oe}, 64'h0);
        check("R10 out", {32'h0, pin_out}, 64'h0);
        check("R7 idle rvalid", {63'h0, rvalid}, 64'h0);
        for (int i = 0; i < 8; i++) begin
            bus_read(AW'(i * 4), got);
            check("R10 reg read", {32'h0, got}, 64'h0);
        end

        pin_in = 32'hA5A5A5A5;
        repeat (3) @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) begin
                bus_write(VECS[v].addr, VECS[v].data);
            end else begin
                bus_read(VECS[v].addr, got);
                check($sformatf("R2-vector %0d", v), {32'h0, got}, {32'h0, VECS[v].exp});
            end
        end

        check("R1 pin_out", {32'h0, pin_out}, 64'h0000_0000_0000_5678);
        check("R1 pin_oe", {32'h0, pin_oe}, 64'h0000_0000_0000_FFFF);
        check("R4 ctl_icfg", ctl_icfg, 64'h01234567_11111111);
        check("R11 ctl_mask", {32'h0, ctl_mask}, {32'h0, 32'hF0F0F0F0});

        // R5 absent variant received the same writes
        check("R5 absent port", {32'h0, both_nb}, 64'h0);
        bus_write(6'h1C, 32'hFFFF0000);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = 6'h1C;
        @(negedge clk);
        sel = 1'b0;
        check("R5 absent read", {32'h0, rdata_nb}, 64'h0);
        check("R5 present read", {32'h0, rdata}, 64'h0000_0000_FFFF_0000);

        // R9 synchronizer latency
        @(negedge clk);
        pin_in = 32'h5A5A5A5A;
        @(negedge clk);
        check("R9 one edge", {32'h0, pad_level}, {32'h0, 32'hA5A5A5A5});
        @(negedge clk);
        check("R9 two edges", {32'h0, pad_level}, {32'h0, 32'h5A5A5A5A});
        bus_read(6'h00, got);
        check("R2 after pad change", {32'h0, got}, {32'h0, 32'h5A5A5678});

        // R8 status set / clear / priority
        @(negedge clk);
        irq_set = 32'h00000300;
        @(negedge clk);
        irq_set = '0;
        check("R8 set", {32'h0, ctl_stat}, 64'h300);
        bus_write(6'h18, 32'h00000100);
        bus_read(6'h18, got);
        check("R8 w1c", {32'h0, got}, 64'h200);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 6'h18; wdata = 32'h00000200;
        irq_set = 32'h00000200;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; irq_set = '0;
        check("R8 set wins", {32'h0, ctl_stat}, 64'h200);
        bus_write(6'h18, 32'h00000000);
        check("R8 write zero keeps", {32'h0, ctl_stat}, 64'h200);
        bus_write(6'h18, 32'h00000200);
        check("R8 clear", {32'h0, ctl_stat}, 64'h0);

        // R10 mid-run reset
        @(negedge clk);
        irq_set = 32'h1;
        @(negedge clk);
        irq_set = '0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 dir", {32'h0, ctl_dir}, 64'h0);
        check("R10 cfg", ctl_icfg, 64'h0);
        check("R10 mask", {32'h0, ctl_mask}, 64'h0);
        check("R10 stat", {32'h0, ctl_stat}, 64'h0);
        check("R10 both", {32'h0, ctl_both}, 64'h0);
        check("R10 pad", {32'h0, pad_level}, 64'h0);
        rst_n = 1'b1;
        bus_read(6'h00, got);
        check("R10 data", {32'h0, got & ~32'h5A5A5A5A}, 64'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule